// File: doc/BRIEF.md
# Auto-Detecting Keyboard Serial Receiver

This block sits on the host side of a two-wire, open-collector keyboard link and turns the keyboard's clocked bit stream into bytes. It does not need to be told which framing the keyboard uses. Three framings are supported: the eleven-bit frame with start, parity and stop bits; the ten-bit older frame that opens with a 0 and then a 1 start bit; and the nine-bit clone frame that has a single 1 start bit. Every sampled bit is shifted into the top of a sixteen-bit register that is preset to `0x8000`. The preset 1 therefore walks down the register one place per bit and marks how many bits have arrived. The low byte of the register, checked after each shift, tells the block whether the frame is still in progress, complete, ambiguous or illegal.

Two low-byte patterns (`0xC0` and `0xA0`) can mean either a complete short frame or a longer frame still in progress. While no protocol is known, the block settles the question by waiting a bounded number of microseconds for one more clock fall. The first framing decoded this way is remembered, and later frames are decoded at once without the wait. When a frame fails, or when the consumer is not ready, the block asks the pad logic to hold the keyboard clock low. The keyboard then stops sending.

Inputs are the raw clock and data line levels, a one-microsecond strobe and a ready flag from the consumer. Outputs are a one-cycle byte strobe with its data, the remembered protocol code, a one-cycle error strobe with its code, and the clock-hold request.

Top module: `kbd_rx_autodetect`

## Requirements
- R1: After reset, `inhibit_o`, `byte_valid`, `err_valid`, `proto_o` and `err_code` are all 0.
- R2: A frame made of start 0, eight data bits sent LSB first, an odd parity bit and stop 1 produces `byte_valid` with that data byte and sets `proto_o` to 1.
- R3: In an eleven-bit frame, the eight data bits and the parity bit together must hold an odd number of ones. If they do not, the block pulses `err_valid` with `err_code` 1, emits no byte and leaves `proto_o` unchanged.
- R4: An eleven-bit frame with correct parity and a stop bit of 0 still delivers its byte, but sets `proto_o` to 2.
- R5: An eleven-bit frame carrying data `0xAA` with wrong parity and stop 1 is reported with `err_code` 2 instead of 1.
- R6: With no protocol stored, a frame of one 1 start bit and eight data bits is complete only after the clock has stayed without a fall for WAIT_US microseconds after its ninth fall. It then delivers the byte and sets `proto_o` to 4.
- R7: With no protocol stored, a frame of start bits 0 then 1 followed by eight data bits is delivered with `proto_o` 3 once WAIT_US microseconds pass without a fall after its tenth fall. An eleven-bit frame whose first data bit is 1 reaches the same pattern, but continues when its eleventh fall arrives inside that window.
- R8: A frame whose two start bits are both sampled as 1, followed by eight data bits, delivers its byte with `proto_o` 5.
- R9: Once `proto_o` is nonzero, an ambiguous pattern is resolved at once from the stored code, with no wait. With code 4 stored, a one-start-bit frame's byte appears within a few cycles of its ninth fall.
- R10: A shift-register low byte outside every legal pattern (for example the start-bit pair 1 then 0, which yields `0x60`) pulses `err_valid` with `err_code` 3 and clears `proto_o` to 0.
- R11: If more than GAP_US microseconds pass without a clock fall after a frame has begun, the block pulses `err_valid` with `err_code` 4. It drops the partial frame, so the next whole frame decodes correctly.
- R12: Every error raises `inhibit_o` in the same cycle as `err_valid`. `inhibit_o` then stays high for INHIBIT_US microseconds and falls by itself.
- R13: While `sink_ready` is 0, `inhibit_o` is 1 from the next cycle on. Clock falls during that time are discarded and produce no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_clk_i | input | 1 | Raw keyboard clock line level |
| kbd_dat_i | input | 1 | Raw keyboard data line level |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| sink_ready | input | 1 | Consumer can accept bytes |
| inhibit_o | output | 1 | Request to hold keyboard clock low |
| byte_valid | output | 1 | One-cycle strobe: byte_data holds a new byte |
| byte_data | output | 8 | Last received byte |
| proto_o | output | 3 | Stored protocol: 0 none, 1 standard 11-bit, 2 11-bit with low stop, 3 two-start-bit, 4 one-start-bit, 5 misread two-start-bit |
| err_valid | output | 1 | One-cycle strobe: err_code holds a new error |
| err_code | output | 3 | Last error: 1 parity, 2 parity on 0xAA, 3 illegal pattern, 4 clock gap timeout |

## Verification
A raw line change needs two synchroniser flops and the previous-level register before it counts as a fall, and the decision is registered one edge later. A frame that the pattern alone settles therefore reports about three cycles after its last clock fall. A frame settled by the probe window reports about WAIT_US ticks plus three cycles after that fall, and a timeout reports about GAP_US ticks after the last fall. The bench samples on falling clock edges. A monitor latches every byte and error strobe, and each frame is judged only after a settling gap that is longer than the probe window and the inhibit period. The no-wait case of R9 and the wait case of R6 are told apart by sampling twenty cycles after the ninth fall: by then the first must have reported and the second must not have.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

  typedef enum logic [2:0] {
    PROTO_NONE      = 3'd0,
    PROTO_STD11     = 3'd1,
    PROTO_STD11_LOW = 3'd2,
    PROTO_XT_TWO    = 3'd3,
    PROTO_XT_ONE    = 3'd4,
    PROTO_XT_BAD    = 3'd5
  } proto_e;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_PARITY    = 3'd1,
    ERR_PARITY_AA = 3'd2,
    ERR_ILLEGAL   = 3'd3,
    ERR_TIMEOUT   = 3'd4
  } err_e;

  typedef enum logic [1:0] {
    ACT_MORE,
    ACT_PROBE,
    ACT_DONE,
    ACT_FAIL
  } act_e;

  localparam int          SREG_W    = 16;
  localparam logic [15:0] SREG_IDLE = 16'h8000;
  localparam logic [15:0] SREG_AA_BAD = 16'hAA90;

endpackage

// File: rtl/kbd_sync.sv
module kbd_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= {WIDTH{RST_VAL}};
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/kbd_us_counter.sv
module kbd_us_counter #(
  parameter int MAX = 100,
  parameter int W   = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = W'(MAX);

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/kbd_classify.sv
module kbd_classify
  import kbd_rx_pkg::*;
(
  input  logic [15:0] nxt_i,
  input  proto_e      proto_i,
  output act_e        act_o,
  output logic [7:0]  byte_o,
  output proto_e      proto_o,
  output err_e        err_o,
  output logic        clr_proto_o
);

  logic par_odd;
  assign par_odd = ^nxt_i[14:6];

  always_comb begin
    act_o       = ACT_MORE;
    byte_o      = nxt_i[15:8];
    proto_o     = proto_i;
    err_o       = ERR_NONE;
    clr_proto_o = 1'b0;
    unique case (nxt_i[7:0])
      8'h00, 8'h80, 8'h40, 8'h20: act_o = ACT_MORE;
      8'hC0: begin
        if (proto_i == PROTO_XT_ONE) begin
          act_o   = ACT_DONE;
          proto_o = PROTO_XT_ONE;
        end else if (proto_i != PROTO_NONE) begin
          act_o = ACT_MORE;
        end else begin
          act_o = ACT_PROBE;
        end
      end
      8'hA0: begin
        if (proto_i == PROTO_XT_TWO) begin
          act_o   = ACT_DONE;
          proto_o = PROTO_XT_TWO;
        end else if (proto_i != PROTO_NONE) begin
          act_o = ACT_MORE;
        end else begin
          act_o = ACT_PROBE;
        end
      end
      8'hE0: begin
        act_o   = ACT_DONE;
        proto_o = PROTO_XT_BAD;
      end
      8'h10, 8'h90, 8'h50, 8'hD0: begin
        byte_o = nxt_i[13:6];
        if (nxt_i == SREG_AA_BAD) begin
          act_o = ACT_FAIL;
          err_o = ERR_PARITY_AA;
        end else if (!par_odd) begin
          act_o = ACT_FAIL;
          err_o = ERR_PARITY;
        end else begin
          act_o   = ACT_DONE;
          proto_o = nxt_i[15] ? PROTO_STD11 : PROTO_STD11_LOW;
        end
      end
      default: begin
        act_o       = ACT_FAIL;
        err_o       = ERR_ILLEGAL;
        clr_proto_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/kbd_rx_autodetect.sv
module kbd_rx_autodetect
  import kbd_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_US     = 100,
  parameter int GAP_US      = 2000,
  parameter int INHIBIT_US  = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  input  logic       us_tick,
  input  logic       sink_ready,
  output logic       inhibit_o,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [2:0] proto_o,
  output logic       err_valid,
  output logic [2:0] err_code
);

  localparam int FT_MAX = (GAP_US > WAIT_US) ? GAP_US : WAIT_US;
  localparam int FT_W   = $clog2(FT_MAX + 1);
  localparam int IH_W   = $clog2(INHIBIT_US + 1);
  localparam logic [FT_W-1:0] WAIT_LIM = FT_W'(WAIT_US);
  localparam logic [FT_W-1:0] GAP_LIM  = FT_W'(GAP_US);
  localparam logic [IH_W-1:0] IH_LIM   = IH_W'(INHIBIT_US);

  // line synchronisers: bit 0 clock, bit 1 data
  logic [1:0] line_s;
  logic       clk_prev_q;
  logic       kfall;

  kbd_sync #(.STAGES(SYNC_STAGES), .WIDTH(2), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({kbd_dat_i, kbd_clk_i}),
    .sync_o  (line_s)
  );

  assign kfall = clk_prev_q & ~line_s[0];

  // state
  logic [15:0] sreg_q,  sreg_d;
  logic        probe_q, probe_d;
  proto_e      proto_q, proto_d;
  logic        inh_busy_q, inh_busy_d;
  logic        bv_d, ev_d;
  logic [7:0]  bd_d;
  err_e        ec_q, ec_d;
  logic        fail;
  logic        ft_clr;
  logic        hold;

  logic [FT_W-1:0] ft_cnt;
  logic [IH_W-1:0] ih_cnt;

  kbd_us_counter #(.MAX(FT_MAX)) u_frame_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (ft_clr),
    .tick (us_tick),
    .cnt  (ft_cnt)
  );

  kbd_us_counter #(.MAX(INHIBIT_US)) u_inhibit_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (fail),
    .tick (us_tick & inh_busy_q),
    .cnt  (ih_cnt)
  );

  // classification of the shifted value
  logic [15:0] sreg_shift;
  act_e        cls_act;
  logic [7:0]  cls_byte;
  proto_e      cls_proto;
  err_e        cls_err;
  logic        cls_clr;

  assign sreg_shift = {line_s[1], sreg_q[15:1]};

  kbd_classify u_classify (
    .nxt_i       (sreg_shift),
    .proto_i     (proto_q),
    .act_o       (cls_act),
    .byte_o      (cls_byte),
    .proto_o     (cls_proto),
    .err_o       (cls_err),
    .clr_proto_o (cls_clr)
  );

  assign hold = inh_busy_q | ~sink_ready;

  always_comb begin
    sreg_d  = sreg_q;
    probe_d = probe_q;
    proto_d = proto_q;
    bv_d    = 1'b0;
    bd_d    = byte_data;
    ev_d    = 1'b0;
    ec_d    = ec_q;
    fail    = 1'b0;
    ft_clr  = 1'b0;

    if (hold) begin
      sreg_d  = SREG_IDLE;
      probe_d = 1'b0;
      ft_clr  = 1'b1;
    end else if (kfall) begin
      ft_clr = 1'b1;
      unique case (cls_act)
        ACT_MORE: begin
          sreg_d  = sreg_shift;
          probe_d = 1'b0;
        end
        ACT_PROBE: begin
          sreg_d  = sreg_shift;
          probe_d = 1'b1;
        end
        ACT_DONE: begin
          bv_d    = 1'b1;
          bd_d    = cls_byte;
          proto_d = cls_proto;
          sreg_d  = SREG_IDLE;
          probe_d = 1'b0;
        end
        default: begin
          ev_d    = 1'b1;
          ec_d    = cls_err;
          fail    = 1'b1;
          sreg_d  = SREG_IDLE;
          probe_d = 1'b0;
          if (cls_clr) proto_d = PROTO_NONE;
        end
      endcase
    end else if (probe_q) begin
      if (ft_cnt >= WAIT_LIM) begin
        bv_d    = 1'b1;
        bd_d    = sreg_q[15:8];
        proto_d = (sreg_q[7:0] == 8'hC0) ? PROTO_XT_ONE : PROTO_XT_TWO;
        sreg_d  = SREG_IDLE;
        probe_d = 1'b0;
        ft_clr  = 1'b1;
      end
    end else if (sreg_q == SREG_IDLE) begin
      ft_clr = 1'b1;
    end else if (ft_cnt >= GAP_LIM) begin
      ev_d   = 1'b1;
      ec_d   = ERR_TIMEOUT;
      fail   = 1'b1;
      sreg_d = SREG_IDLE;
      ft_clr = 1'b1;
    end

    inh_busy_d = fail | (inh_busy_q & (ih_cnt != IH_LIM));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev_q <= 1'b1;
      sreg_q     <= SREG_IDLE;
      probe_q    <= 1'b0;
      proto_q    <= PROTO_NONE;
      inh_busy_q <= 1'b0;
      inhibit_o  <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      err_valid  <= 1'b0;
      ec_q       <= ERR_NONE;
    end else begin
      clk_prev_q <= line_s[0];
      sreg_q     <= sreg_d;
      probe_q    <= probe_d;
      proto_q    <= proto_d;
      inh_busy_q <= inh_busy_d;
      inhibit_o  <= inh_busy_d | ~sink_ready;
      byte_valid <= bv_d;
      byte_data  <= bd_d;
      err_valid  <= ev_d;
      ec_q       <= ec_d;
    end
  end

  assign proto_o  = proto_q;
  assign err_code = ec_q;

endmodule

// File: rtl/kbd_rx_autodetect_chk.sv
module kbd_rx_autodetect_chk (
  input logic       clk,
  input logic       rst,
  input logic       sink_ready,
  input logic       inhibit_o,
  input logic       byte_valid,
  input logic [2:0] proto_o,
  input logic       err_valid,
  input logic [2:0] err_code
);

  AST_BYTE_OR_ERR: assert property (@(posedge clk) disable iff (rst)
    !(byte_valid && err_valid)); // R3

  AST_ERR_INHIBITS: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> inhibit_o); // R12

  AST_NOTREADY_INHIBITS: assert property (@(posedge clk) disable iff (rst)
    !sink_ready |=> inhibit_o); // R13

  AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == 3'd3) |-> proto_o == 3'd0); // R10

  AST_PROTO_HELD: assert property (@(posedge clk) disable iff (rst)
    (!byte_valid && !err_valid) |-> $stable(proto_o)); // R9

  AST_ERR_CODE_SET: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> err_code != 3'd0); // R11

endmodule

bind kbd_rx_autodetect kbd_rx_autodetect_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sink_ready (sink_ready),
  .inhibit_o  (inhibit_o),
  .byte_valid (byte_valid),
  .proto_o    (proto_o),
  .err_valid  (err_valid),
  .err_code   (err_code)
);

// File: tb/kbd_rx_autodetect_test.sv
`timescale 1ns/1ps
module kbd_rx_autodetect_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic       sink_ready = 1'b1;
  logic       inhibit_o, byte_valid, err_valid;
  logic [7:0] byte_data;
  logic [2:0] proto_o, err_code;

  int checks = 0;
  int errors = 0;

  logic       got_v;
  logic [7:0] got_b;
  logic       got_e;
  logic [2:0] got_ec;

  always #4 clk = ~clk;

  kbd_rx_autodetect uut (
    .clk        (clk),
    .rst        (rst),
    .kbd_clk_i  (kclk),
    .kbd_dat_i  (kdat),
    .us_tick    (1'b1),
    .sink_ready (sink_ready),
    .inhibit_o  (inhibit_o),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .proto_o    (proto_o),
    .err_valid  (err_valid),
    .err_code   (err_code)
  );

  always @(negedge clk) begin
    if (byte_valid) begin got_v = 1'b1; got_b = byte_data; end
    if (err_valid)  begin got_e = 1'b1; got_ec = err_code; end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle(5);
    rst = 1'b0;
    idle(5);
  endtask

  task automatic clr_mon();
    got_v = 1'b0; got_b = '0; got_e = 1'b0; got_ec = '0;
  endtask

  task automatic send_bit(input logic b);
    kdat = b;
    idle(20);
    kclk = 1'b0;
    idle(20);
    kclk = 1'b1;
  endtask

  // frame kinds: 0 std11, 1 std11 bad parity, 2 std11 low stop,
  // 3 one-start, 4 two-start, 5 two-start misread, 6 illegal start pair
  task automatic send_frame(input int kind, input logic [7:0] d);
    logic par;
    par = ~^d;
    case (kind)
      0, 1, 2: send_bit(1'b0);
      3:       send_bit(1'b1);
      4:       begin send_bit(1'b0); send_bit(1'b1); end
      5:       begin send_bit(1'b1); send_bit(1'b1); end
      default: begin send_bit(1'b1); send_bit(1'b0); end
    endcase
    for (int i = 0; i < 8; i++) send_bit((kind == 6) ? 1'b0 : d[i]);
    if (kind <= 2) begin
      send_bit((kind == 1) ? ~par : par);
      send_bit((kind == 2) ? 1'b0 : 1'b1);
    end
  endtask

  function automatic string tag_of(input int kind, input logic [7:0] d);
    case (kind)
      0: return (d[0]) ? "R7" : "R2";
      1: return (d == 8'hAA) ? "R5" : "R3";
      2: return "R4";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R10";
    endcase
  endfunction

  // {reset_first, kind[2:0], data[7:0], exp_valid, exp_proto[2:0], exp_err[2:0]}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'h1C, 1'b1, 3'd1, 3'd0},
    {1'b0, 3'd0, 8'hF1, 1'b1, 3'd1, 3'd0},
    {1'b0, 3'd1, 8'h33, 1'b0, 3'd1, 3'd1},
    {1'b0, 3'd2, 8'h5A, 1'b1, 3'd2, 3'd0},
    {1'b1, 3'd1, 8'hAA, 1'b0, 3'd0, 3'd2},
    {1'b1, 3'd3, 8'h3C, 1'b1, 3'd4, 3'd0},
    {1'b0, 3'd3, 8'h81, 1'b1, 3'd4, 3'd0},
    {1'b1, 3'd4, 8'h45, 1'b1, 3'd3, 3'd0},
    {1'b1, 3'd5, 8'h12, 1'b1, 3'd5, 3'd0},
    {1'b0, 3'd6, 8'h00, 1'b0, 3'd0, 3'd3},
    {1'b1, 3'd0, 8'hA1, 1'b1, 3'd1, 3'd0}
  };

  initial begin
    clr_mon();
    idle(5);
    rst = 1'b0;
    idle(5);

    // R1 reset state
    chk("R1", inhibit_o,  0, "inhibit");
    chk("R1", byte_valid, 0, "byte_valid");
    chk("R1", err_valid,  0, "err_valid");
    chk("R1", proto_o,    0, "proto");
    chk("R1", err_code,   0, "err_code");

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      string t;
      e = VEC[v];
      t = tag_of(int'(e[17:15]), e[14:7]);
      if (e[18]) do_reset();
      clr_mon();
      send_frame(int'(e[17:15]), e[14:7]);
      idle(400);
      chk(t, got_v, int'(e[6]), "byte strobe");
      if (e[6]) chk(t, got_b, int'(e[14:7]), "byte");
      chk(t, proto_o, int'(e[5:3]), "proto");
      chk(t, got_e ? int'(got_ec) : 0, int'(e[2:0]), "error");
    end

    // R6 / R9: probe wait versus stored protocol
    do_reset();
    clr_mon();
    send_frame(3, 8'h3C);
    chk("R6", got_v, 0, "no byte before window");
    idle(300);
    chk("R6", got_v, 1, "byte after window");
    clr_mon();
    send_frame(3, 8'h7E);
    chk("R9", got_v, 1, "byte without wait");
    chk("R9", got_b, 8'h7E, "byte");

    // R11 / R12: gap timeout, inhibit period, restart
    do_reset();
    clr_mon();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    idle(2100);
    chk("R11", got_e ? int'(got_ec) : 0, 4, "timeout error");
    chk("R12", inhibit_o, 1, "inhibit held");
    idle(300);
    chk("R12", inhibit_o, 0, "inhibit released");
    clr_mon();
    send_frame(0, 8'h2B);
    idle(300);
    chk("R11", got_v, 1, "restart byte strobe");
    chk("R11", got_b, 8'h2B, "restart byte");

    // R13: consumer not ready
    do_reset();
    clr_mon();
    sink_ready = 1'b0;
    idle(3);
    chk("R13", inhibit_o, 1, "inhibit when not ready");
    send_frame(0, 8'h66);
    idle(300);
    chk("R13", got_v, 0, "no byte while not ready");
    sink_ready = 1'b1;
    idle(3);
    chk("R13", inhibit_o, 0, "inhibit dropped");
    clr_mon();
    send_frame(0, 8'h66);
    idle(300);
    chk("R13", got_b, 8'h66, "byte after ready");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule